// File: doc/BRIEF.md
# Register-Exchange Viterbi Decoder with Per-Packet Constraint Length

This block decodes a hard-decision, rate-1/2 convolutional code. Each trellis step takes one received two-bit symbol and updates every state in a single clock cycle. The update runs through an array of add-compare-select butterflies, and each butterfly produces two new states. The decoded path is kept by register exchange. Every state owns a history word of decoded bits, and each step copies the history of the winning predecessor into it. No traceback search takes place.

The constraint length is chosen per packet by a two-bit selector that is sampled with the first symbol. The choices are 5, 7 and 9, which give 16, 64 or 256 states. Every butterfly lane always handles two states. A smaller code simply leaves the upper lanes idle, so one control sequence serves all three codes. New metrics and histories are written in even-first order: slot p holds state 2p, and slot p+N/2 holds state 2p+1. A read permutation restores the predecessor pairs for the next step.

A packet carries 64 information bits, followed by K-1 zero tail bits that return the encoder to state 0. After the final tail symbol, the history of state 0 is streamed out one bit per cycle.

Top module: `rxv_decoder`

## Requirements
- R1: A symbol is consumed on every rising clock edge where `sym_valid` and `sym_ready` are both high. Cycles with `sym_valid` low change nothing, however many there are.
- R2: `k_sel` is sampled together with the first symbol of a packet. Code 0 selects K=5, code 1 selects K=7, and codes 2 and 3 select K=9. Changes to `k_sel` later in the packet have no effect.
- R3: A packet is exactly 64+K-1 symbols. `out_valid` first goes high in the cycle after the last symbol is accepted, and not earlier.
- R4: The 64 decoded bits leave on 64 consecutive cycles, oldest information bit first, with `out_last` high on the 64th. `sym_ready` is low throughout this output phase and high again in the next cycle.
- R5: The code taps, in octal, are 23/35 for K=5, 171/133 for K=7 and 561/753 for K=9. The encoder window has bit j equal to the input j steps ago, with bit 0 the current bit. `sym_data[0]` is the parity of the window with the first polynomial, and `sym_data[1]` is the parity with the second. The encoder starts at zero and is flushed with zeros. An error-free packet decodes exactly.
- R6: A packet with any single flipped received bit still decodes exactly.
- R7: Every packet starts with a metric of 0 for state 0 and the saturated maximum for all other states. No state carries over from the previous packet, whatever its constraint length or errors.
- R8: While reset is held and in the first cycle after it, `sym_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Received symbol present |
| sym_ready | output | 1 | Decoder accepts a symbol |
| sym_data | input | 2 | Received hard-decision pair |
| k_sel | input | 2 | Constraint-length code for the packet |
| out_valid | output | 1 | Decoded bit present |
| out_bit | output | 1 | Decoded information bit |
| out_last | output | 1 | Final decoded bit of the packet |

## Verification
The bench builds the decoder with its default widths. These are the nine-bit saturating metrics, 64-bit histories and 128 butterfly lanes, so every selectable constraint length runs on the full lane array. For K=5 and K=7 the upper lanes sit idle, and any leak from them would corrupt the decoded word. Random packets are encoded in each mode by an independent encoder. Some are sent clean, some with a flipped bit near the start, middle or tail, some with stalls in the input, some with `k_sel` changed mid-packet, and some back to back across modes. Each decoded word and each output-phase boundary is compared with the expected values.

// File: rtl/rxv_pkg.sv
package rxv_pkg;

    localparam int KMAX   = 9;
    localparam int SBITS  = KMAX - 1;
    localparam int NSM    = 1 << SBITS;
    localparam int NLANE  = NSM / 2;
    localparam int PMW    = 9;
    localparam int HW     = 64;
    localparam int IW     = $clog2(HW);
    localparam int CW     = $clog2(HW + KMAX);
    localparam logic [PMW-1:0] PM_MAX = '1;

    typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_EMIT} phase_t;

    typedef struct packed {
        logic [PMW-1:0] pm;
        logic [HW-1:0]  hist;
    } surv_t;

    function automatic logic [1:0] kc_norm(input logic [1:0] raw);
        return (raw == 2'd3) ? 2'd2 : raw;
    endfunction

    function automatic int k_len(input logic [1:0] kc);
        case (kc)
            2'd0:    return 5;
            2'd1:    return 7;
            default: return 9;
        endcase
    endfunction

    function automatic int half_of(input logic [1:0] kc);
        return 1 << (k_len(kc) - 2);
    endfunction

    function automatic logic [KMAX-1:0] gpoly(input logic [1:0] kc, input logic second);
        case (kc)
            2'd0:    return second ? KMAX'(9'o035) : KMAX'(9'o023);
            2'd1:    return second ? KMAX'(9'o133) : KMAX'(9'o171);
            default: return second ? KMAX'(9'o753) : KMAX'(9'o561);
        endcase
    endfunction

    function automatic logic [1:0] code_pair(input logic [1:0] kc, input logic [KMAX-1:0] w);
        return {^(w & gpoly(kc, 1'b1)), ^(w & gpoly(kc, 1'b0))};
    endfunction

    function automatic logic [1:0] hamming2(input logic [1:0] a, input logic [1:0] b);
        logic [1:0] d;
        d = a ^ b;
        return {1'b0, d[0]} + {1'b0, d[1]};
    endfunction

    function automatic logic [PMW-1:0] sat_add(input logic [PMW-1:0] pm, input logic [1:0] bm);
        logic [PMW:0] s;
        s = {1'b0, pm} + {{(PMW-1){1'b0}}, bm};
        return s[PMW] ? PM_MAX : s[PMW-1:0];
    endfunction

    function automatic logic [SBITS-1:0] slot_of(input int s, input int half);
        int r;
        r = (s % 2 == 1) ? (s / 2) + half : s / 2;
        return SBITS'(r);
    endfunction

endpackage

// File: rtl/rxv_butterfly.sv
module rxv_butterfly
    import rxv_pkg::*;
#(
    parameter int LANE = 0
) (
    input  logic [1:0] kc,
    input  logic [1:0] rx,
    input  logic       shift_en,
    input  surv_t      pa,
    input  surv_t      pb,
    output surv_t      o0,
    output surv_t      o1
);

    // one compare-select for new state 2*LANE+j; pa is the lower-index predecessor
    function automatic surv_t acs(input logic j, input logic [1:0] k, input logic [1:0] r,
                                  input logic sh, input surv_t a, input surv_t b);
        logic [KMAX-1:0] wa, wb;
        logic [PMW-1:0]  ma, mb;
        surv_t           win;
        wa = KMAX'(2 * LANE) | KMAX'(j);
        wb = wa | (KMAX'(1) << (k_len(k) - 1));
        ma = sat_add(a.pm, hamming2(r, code_pair(k, wa)));
        mb = sat_add(b.pm, hamming2(r, code_pair(k, wb)));
        if (mb < ma) begin
            win.pm   = mb;
            win.hist = b.hist;
        end else begin
            win.pm   = ma;
            win.hist = a.hist;
        end
        if (sh) win.hist = {win.hist[HW-2:0], j};
        return win;
    endfunction

    assign o0 = acs(1'b0, kc, rx, shift_en, pa, pb);
    assign o1 = acs(1'b1, kc, rx, shift_en, pa, pb);

endmodule

// File: rtl/rxv_seq.sv
module rxv_seq
    import rxv_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sym_valid,
    input  logic [1:0]    k_sel,
    output logic          sym_ready,
    output logic          step,
    output logic [1:0]    kc,
    output logic          shift_en,
    output logic          init,
    output logic          emit,
    output logic [IW-1:0] eidx
);

    phase_t        ph;
    logic [1:0]    kc_q;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;
    logic          last_step;

    assign sym_ready = (ph != PH_EMIT);
    assign step      = sym_valid && sym_ready;
    assign kc        = (ph == PH_IDLE) ? kc_norm(k_sel) : kc_q;
    assign shift_en  = (cnt < CW'(HW));
    assign emit      = (ph == PH_EMIT);
    assign eidx      = idx;
    assign init      = emit && (idx == IW'(HW - 1));
    assign last_step = (cnt == CW'(HW + k_len(kc) - 2));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            kc_q <= 2'd0;
            cnt  <= '0;
            idx  <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (step) begin
                    kc_q <= kc;
                    cnt  <= CW'(1);
                    ph   <= PH_RUN;
                end
                PH_RUN: if (step) begin
                    cnt <= cnt + CW'(1);
                    if (last_step) begin
                        ph  <= PH_EMIT;
                        idx <= '0;
                    end
                end
                PH_EMIT: begin
                    idx <= idx + IW'(1);
                    if (init) begin
                        ph  <= PH_IDLE;
                        cnt <= '0;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rxv_decoder.sv
module rxv_decoder
    import rxv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_valid,
    output logic       sym_ready,
    input  logic [1:0] sym_data,
    input  logic [1:0] k_sel,
    output logic       out_valid,
    output logic       out_bit,
    output logic       out_last
);

    logic          step, shift_en, init, emit;
    logic [1:0]    kc;
    logic [IW-1:0] eidx;
    int            half;

    surv_t st   [NSM];
    surv_t la_a [NLANE];
    surv_t la_b [NLANE];
    surv_t lo0  [NLANE];
    surv_t lo1  [NLANE];

    rxv_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .sym_valid (sym_valid),
        .k_sel     (k_sel),
        .sym_ready (sym_ready),
        .step      (step),
        .kc        (kc),
        .shift_en  (shift_en),
        .init      (init),
        .emit      (emit),
        .eidx      (eidx)
    );

    assign half = half_of(kc);

    // un-shuffle: lane m needs states m and m+half from the even-first store
    always_comb begin
        for (int m = 0; m < NLANE; m++) begin
            la_a[m] = st[slot_of(m, half)];
            la_b[m] = st[slot_of(m + half, half)];
        end
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        rxv_butterfly #(.LANE(g)) u_bf (
            .kc       (kc),
            .rx       (sym_data),
            .shift_en (shift_en),
            .pa       (la_a[g]),
            .pb       (la_b[g]),
            .o0       (lo0[g]),
            .o1       (lo1[g])
        );
    end

    // shuffled write: slot p <- state 2p, slot p+half <- state 2p+1
    always_ff @(posedge clk) begin
        if (rst || init) begin
            for (int s = 0; s < NSM; s++) begin
                st[s].pm   <= (s == 0) ? '0 : PM_MAX;
                st[s].hist <= '0;
            end
        end else if (step) begin
            for (int p = 0; p < NLANE; p++) begin
                if (p < half) begin
                    st[p]                 <= lo0[p];
                    st[SBITS'(p + half)] <= lo1[p];
                end
            end
        end
    end

    assign out_valid = emit;
    assign out_bit   = st[0].hist[IW'(HW - 1) - eidx];
    assign out_last  = init;

endmodule

// File: rtl/rxv_decoder_chk.sv
module rxv_decoder_chk (
    input logic clk,
    input logic rst,
    input logic sym_valid,
    input logic sym_ready,
    input logic out_valid,
    input logic out_last
);

    // R4
    busy_gap_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !sym_ready);

    // R4
    last_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R4
    reopen_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |=> (!out_valid && sym_ready));

    // R3
    start_after_symbol_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(sym_valid && sym_ready));

    // R4
    end_on_last_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> $past(out_last));

endmodule

bind rxv_decoder rxv_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sym_valid (sym_valid),
    .sym_ready (sym_ready),
    .out_valid (out_valid),
    .out_last  (out_last)
);

// File: tb/rxv_decoder_tb.sv
module rxv_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int INFO = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_valid = 1'b0;
    logic       sym_ready;
    logic [1:0] sym_data = 2'b00;
    logic [1:0] k_sel = 2'b00;
    logic       out_valid, out_bit, out_last;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rxv_decoder u_dut (
        .clk       (clk),
        .rst       (rst),
        .sym_valid (sym_valid),
        .sym_ready (sym_ready),
        .sym_data  (sym_data),
        .k_sel     (k_sel),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_last  (out_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int klen(input int code);
        return (code == 0) ? 5 : (code == 1) ? 7 : 9;
    endfunction

    function automatic logic [8:0] tb_poly(input int k, input bit second);
        if (k == 5) return second ? 9'o035 : 9'o023;
        if (k == 7) return second ? 9'o133 : 9'o171;
        return second ? 9'o753 : 9'o561;
    endfunction

    // sends one packet; errpos < 0 means no injected error
    task automatic run_pkt(input string req, input int code, input logic [63:0] data,
                           input int errpos, input int errbit, input bit kflip, input bit gaps);
        int k, total;
        logic [8:0] sreg, w;
        logic [1:0] syms [72];
        logic [63:0] got;
        bit last_ok;
        k = klen(code);
        total = INFO + k - 1;
        sreg = '0;
        for (int t = 0; t < total; t++) begin
            w = ((sreg << 1) | 9'((t < INFO) ? data[63 - t] : 1'b0)) & 9'((1 << k) - 1);
            syms[t] = {^(w & tb_poly(k, 1'b1)), ^(w & tb_poly(k, 1'b0))};
            if (t == errpos) syms[t][errbit] = ~syms[t][errbit];
            sreg = w & 9'((1 << (k - 1)) - 1);
        end
        k_sel = 2'(code);
        for (int t = 0; t < total; t++) begin
            if (gaps && (t % 7 == 3)) begin
                sym_valid = 1'b0;
                @(negedge clk);
            end
            sym_valid = 1'b1;
            sym_data  = syms[t];
            if (kflip && t == 1) k_sel = (code == 0) ? 2'd2 : 2'd0;
            if (t == total - 1)
                check(out_valid == 1'b0, "R3", "no output before last symbol", 64'(out_valid), 64'd0);
            @(negedge clk);
        end
        sym_valid = 1'b0;
        check(out_valid == 1'b1, "R3", "output starts one cycle after last symbol", 64'(out_valid), 64'd1);
        last_ok = 1'b1;
        got = '0;
        for (int i = 0; i < INFO; i++) begin
            got[63 - i] = out_bit;
            if (out_last != (i == INFO - 1) || !out_valid || sym_ready) last_ok = 1'b0;
            @(negedge clk);
        end
        check(last_ok, "R4", "output burst framing", 64'(last_ok), 64'd1);
        check(!out_valid && sym_ready, "R4", "ready returns after last bit",
              {62'd0, out_valid, sym_ready}, 64'd1);
        check(got == data, req, "decoded word", got, data);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(sym_ready && !out_valid, "R8", "state in reset", {62'd0, sym_ready, out_valid}, 64'd2);
        rst = 1'b0;
        @(negedge clk);
        check(sym_ready && !out_valid, "R8", "state after reset", {62'd0, sym_ready, out_valid}, 64'd2);
    endtask

    task automatic t_clean();
        run_pkt("R5", 0, {$urandom, $urandom}, -1, 0, 1'b0, 1'b0);
        run_pkt("R5", 1, {$urandom, $urandom}, -1, 0, 1'b0, 1'b0);
        run_pkt("R5", 2, {$urandom, $urandom}, -1, 0, 1'b0, 1'b0);
        run_pkt("R5", 1, 64'hFFFF_FFFF_FFFF_FFFF, -1, 0, 1'b0, 1'b0);
    endtask

    task automatic t_errors();
        run_pkt("R6", 0, {$urandom, $urandom}, 2, 0, 1'b0, 1'b0);
        run_pkt("R6", 1, {$urandom, $urandom}, 33, 1, 1'b0, 1'b0);
        run_pkt("R6", 2, {$urandom, $urandom}, 70, 0, 1'b0, 1'b0);
        run_pkt("R6", 2, {$urandom, $urandom}, 0, 1, 1'b0, 1'b0);
    endtask

    task automatic t_kselect();
        run_pkt("R2", 3, {$urandom, $urandom}, -1, 0, 1'b0, 1'b0);
        run_pkt("R2", 0, {$urandom, $urandom}, -1, 0, 1'b1, 1'b0);
        run_pkt("R2", 2, {$urandom, $urandom}, -1, 0, 1'b1, 1'b0);
    endtask

    task automatic t_stalls();
        run_pkt("R1", 1, {$urandom, $urandom}, -1, 0, 1'b0, 1'b1);
        run_pkt("R1", 0, {$urandom, $urandom}, 40, 0, 1'b0, 1'b1);
    endtask

    task automatic t_fresh_start();
        run_pkt("R7", 2, 64'h0123_4567_89AB_CDEF, 10, 1, 1'b0, 1'b0);
        run_pkt("R7", 0, 64'h0, -1, 0, 1'b0, 1'b0);
        run_pkt("R7", 1, 64'h8000_0000_0000_0001, -1, 0, 1'b0, 1'b0);
        run_pkt("R7", 0, {$urandom, $urandom}, 60, 1, 1'b0, 1'b0);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_clean();
        t_errors();
        t_kselect();
        t_stalls();
        t_fresh_start();
        finished = 1'b1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "R3", "watchdog expired", 64'd0, 64'd1);
            report();
        end
    end

endmodule